// File: doc/BRIEF.md
# Parallel Strobe Bus Master

This block drives an asynchronous parallel peripheral bus of the kind found on display controllers. The bus has a chip select, a write strobe, a read strobe and a data/command select line, plus a data bus whose pins are driven or released. A host hands the block one request at a time. A write request may carry an optional command word, and its payload words arrive on a valid/ready stream. A read request fetches a single status word. Each transaction is framed by chip select. Every write word is latched by the peripheral on the rising edge of the write strobe. A read samples the bus while the read strobe is still low.

All strobe phases are timed by a divider on the system clock: each phase lasts `cfg_div+1` clocks. The chip-select polarity and the write-strobe polarity can be set. The data/command line level can be set separately for four phases: idle, command, turnaround (dummy) and data. The configuration inputs must be held steady while `busy` is high.

The sequencer has these states. ST_IDLE waits for a request. ST_CMD_HI and ST_CMD_LO set up and strobe the command word. ST_DAT_WAIT waits for the next payload word and raises `pl_ready`. ST_DAT_HI and ST_DAT_LO set up and strobe a payload word. ST_FINISH gives the hold period after the last strobe. ST_RD_TA1, ST_RD_LO and ST_RD_TA2 are the release, strobe and recovery periods of a read.

The transitions are as follows. From ST_IDLE, an accepted request goes to ST_RD_TA1 for a read, to ST_CMD_HI for a write with a command, and to ST_DAT_WAIT for a data-only write. ST_CMD_HI goes to ST_CMD_LO. ST_CMD_LO goes to ST_DAT_WAIT if payload remains, otherwise to ST_FINISH. ST_DAT_WAIT goes to ST_DAT_HI on a handshake. ST_DAT_HI goes to ST_DAT_LO. ST_DAT_LO goes to ST_DAT_WAIT, or to ST_FINISH after the last word. ST_FINISH goes to ST_IDLE. ST_RD_TA1 goes to ST_RD_LO, ST_RD_LO to ST_RD_TA2, and ST_RD_TA2 to ST_IDLE. Every timed state ends when its divider period expires.

Top module: `pbus_master`

## Requirements
- R1: `bus_cs` is active from the cycle after a request is accepted until the transaction ends, and inactive at all other times. Active is low when `cfg_cs_high`=0 and high when it is 1.
- R2: While no word is being strobed, the write strobe rests at its inactive level: high when `cfg_wr_inv`=0, low when it is 1. Each transferred word gives exactly one active pulse. `bus_dout` holds the word unchanged through the pulse and its trailing edge.
- R3: A write with `req_has_cmd`=1 sends `req_cmd` first with `bus_dc`=`cfg_dc_cmd`. It then sends `req_len` payload words in arrival order with `bus_dc`=`cfg_dc_data`, all under one chip select. Without a command, the payload goes out directly at the data level.
- R4: Outside transactions, `bus_dc` equals `cfg_dc_idle`. During the two turnaround periods of a read it equals `cfg_dc_dummy`.
- R5: A read first sets `bus_oe`=0 for one period. It then drives `bus_rd` low for one period with `bus_dc`=`req_rd_dc`, and samples `bus_din` on the last clock of that low period. It then keeps `bus_oe`=0 for one more period. The sampled word appears on `rd_data` together with `done`.
- R6: A write with `req_len` > MAX_LEN, or a write with no command and `req_len`=0, is rejected. Rejection gives a one-cycle `err` pulse in the cycle after the request, and causes no bus activity and no `busy`. Reads ignore `req_len`.
- R7: `req_ready` is high exactly when `busy` is low. `busy` is high from the cycle after acceptance until chip select is released. `done` is a one-cycle pulse in the first cycle after chip select is released.
- R8: `pl_ready` is high only while the block waits for a payload word with the write strobe inactive. While the stream stalls, the strobe stays inactive and chip select stays active.
- R9: Each timed phase lasts exactly `cfg_div+1` clocks. This covers setup, strobe-low, hold and turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | DIVW | Phase length minus one, in clocks |
| cfg_cs_high | input | 1 | 1: chip select active high |
| cfg_wr_inv | input | 1 | 1: write strobe inverted (rests low) |
| cfg_dc_idle | input | 1 | D/C level between transactions |
| cfg_dc_cmd | input | 1 | D/C level for the command word |
| cfg_dc_dummy | input | 1 | D/C level during read turnaround |
| cfg_dc_data | input | 1 | D/C level for payload words |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_read | input | 1 | 1: single-word read |
| req_has_cmd | input | 1 | Write carries a command word |
| req_cmd | input | DW | Command word |
| req_len | input | LENW | Payload word count |
| req_rd_dc | input | 1 | D/C level during the read strobe |
| pl_valid | input | 1 | Payload word offered |
| pl_ready | output | 1 | Payload word taken |
| pl_data | input | DW | Payload word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | One-cycle rejection pulse |
| rd_data | output | DW | Word captured by the last read |
| bus_cs | output | 1 | Chip select pin |
| bus_wr | output | 1 | Write strobe pin |
| bus_rd | output | 1 | Read strobe pin, active low |
| bus_dc | output | 1 | Data/command pin |
| bus_dout | output | DW | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | DW | Data bus input value |

## Verification
The hardest situation to reach from the ports is a payload stall that lands between two words of a burst. The write strobe must then sit inactive, chip select must stay active and `pl_ready` must stay high for an arbitrary time, while the timer is kept from advancing the sequence. The bench feeds payload through a stream driver that inserts different gaps before chosen words, with the divider set above one. This forces ST_DAT_WAIT to be entered both with and without a word already waiting. A behavioural segment-player model predicts every pin on every clock and catches a strobe or data change during the stall. Read turnaround is checked the same way under inverted polarities, and the longest legal burst is run to its limit.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_HI,
        ST_CMD_LO,
        ST_DAT_WAIT,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_FINISH,
        ST_RD_TA1,
        ST_RD_LO,
        ST_RD_TA2
    } seq_state_t;

    typedef enum logic [2:0] {
        DCS_IDLE,
        DCS_CMD,
        DCS_DUMMY,
        DCS_DATA,
        DCS_REQ
    } dc_sel_t;

endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DIVW-1:0] cfg_div,
    output logic            expire
);
    logic [DIVW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= cfg_div;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);

    // a freshly loaded non-zero period cannot expire on its first cycle
    assert_no_early_expire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cfg_div != '0) |=> !expire);
endmodule

// File: rtl/pbus_req_filter.sv
module pbus_req_filter #(
    parameter int MAX_LEN = 1024,
    parameter int LENW    = 12
) (
    input  logic            req_read,
    input  logic            req_has_cmd,
    input  logic [LENW-1:0] req_len,
    output logic            reject
);
    localparam logic [LENW-1:0] LIMIT = LENW'(MAX_LEN);

    logic too_long;
    logic empty_write;

    always_comb begin
        too_long    = (req_len > LIMIT);
        empty_write = !req_has_cmd && (req_len == '0);
        reject      = !req_read && (too_long || empty_write);
    end
endmodule

// File: rtl/pbus_pin_map.sv
module pbus_pin_map
    import pbus_pkg::*;
(
    input  logic    cs_act,
    input  logic    wr_act,
    input  logic    rd_act,
    input  dc_sel_t dc_sel,
    input  logic    rd_dc,
    input  logic    cfg_cs_high,
    input  logic    cfg_wr_inv,
    input  logic    cfg_dc_idle,
    input  logic    cfg_dc_cmd,
    input  logic    cfg_dc_dummy,
    input  logic    cfg_dc_data,
    output logic    bus_cs,
    output logic    bus_wr,
    output logic    bus_rd,
    output logic    bus_dc
);
    always_comb begin
        bus_cs = cfg_cs_high ? cs_act : !cs_act;
        bus_wr = cfg_wr_inv ? wr_act : !wr_act;
        bus_rd = !rd_act;
        unique case (dc_sel)
            DCS_IDLE:  bus_dc = cfg_dc_idle;
            DCS_CMD:   bus_dc = cfg_dc_cmd;
            DCS_DUMMY: bus_dc = cfg_dc_dummy;
            DCS_DATA:  bus_dc = cfg_dc_data;
            DCS_REQ:   bus_dc = rd_dc;
            default:   bus_dc = cfg_dc_idle;
        endcase
    end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int DW   = 8,
    parameter int LENW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_read,
    input  logic            req_has_cmd,
    input  logic [DW-1:0]   req_cmd,
    input  logic [LENW-1:0] req_len,
    input  logic            req_rd_dc,
    input  logic            reject,
    input  logic            expire,
    input  logic            pl_valid,
    input  logic [DW-1:0]   pl_data,
    input  logic [DW-1:0]   bus_din,
    output logic            req_ready,
    output logic            pl_ready,
    output logic            load,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [DW-1:0]   rd_data,
    output logic [DW-1:0]   dout,
    output logic            oe,
    output logic            cs_act,
    output logic            wr_act,
    output logic            rd_act,
    output dc_sel_t         dc_sel,
    output logic            rd_dc
);
    seq_state_t      state_q, state_d;
    logic [LENW-1:0] left_q;
    logic            len_zero_q;
    logic [DW-1:0]   dout_q;
    logic [DW-1:0]   rd_q;
    logic            done_q, err_q, rd_dc_q;
    logic            accept;

    assign accept = (state_q == ST_IDLE) && req_valid && !reject;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (accept)
                    state_d = req_read ? ST_RD_TA1 : (req_has_cmd ? ST_CMD_HI : ST_DAT_WAIT);
            ST_CMD_HI:   if (expire) state_d = ST_CMD_LO;
            ST_CMD_LO:   if (expire) state_d = (left_q != '0) ? ST_DAT_WAIT : ST_FINISH;
            ST_DAT_WAIT: if (pl_valid) state_d = ST_DAT_HI;
            ST_DAT_HI:   if (expire) state_d = ST_DAT_LO;
            ST_DAT_LO:   if (expire) state_d = (left_q == LENW'(1)) ? ST_FINISH : ST_DAT_WAIT;
            ST_FINISH:   if (expire) state_d = ST_IDLE;
            ST_RD_TA1:   if (expire) state_d = ST_RD_LO;
            ST_RD_LO:    if (expire) state_d = ST_RD_TA2;
            ST_RD_TA2:   if (expire) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        cs_act   = 1'b1;
        wr_act   = 1'b0;
        rd_act   = 1'b0;
        oe       = 1'b1;
        pl_ready = 1'b0;
        dc_sel   = DCS_IDLE;
        unique case (state_q)
            ST_IDLE:     cs_act = 1'b0;
            ST_CMD_HI:   dc_sel = DCS_CMD;
            ST_CMD_LO: begin dc_sel = DCS_CMD;  wr_act = 1'b1; end
            ST_DAT_WAIT: begin dc_sel = DCS_DATA; pl_ready = 1'b1; end
            ST_DAT_HI:   dc_sel = DCS_DATA;
            ST_DAT_LO: begin dc_sel = DCS_DATA; wr_act = 1'b1; end
            ST_FINISH:   dc_sel = len_zero_q ? DCS_CMD : DCS_DATA;
            ST_RD_TA1: begin dc_sel = DCS_DUMMY; oe = 1'b0; end
            ST_RD_LO:  begin dc_sel = DCS_REQ;   oe = 1'b0; rd_act = 1'b1; end
            ST_RD_TA2: begin dc_sel = DCS_DUMMY; oe = 1'b0; end
            default:     cs_act = 1'b0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q     <= '0;
            len_zero_q <= 1'b0;
            dout_q     <= '0;
            rd_q       <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            rd_dc_q    <= 1'b0;
        end else begin
            done_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            err_q  <= (state_q == ST_IDLE) && req_valid && reject;
            if (accept) begin
                left_q     <= req_len;
                len_zero_q <= (req_len == '0);
                rd_dc_q    <= req_rd_dc;
                if (req_has_cmd && !req_read)
                    dout_q <= req_cmd;
            end
            if (state_q == ST_DAT_WAIT && pl_valid)
                dout_q <= pl_data;
            if (state_q == ST_DAT_LO && expire)
                left_q <= left_q - 1'b1;
            if (state_q == ST_RD_LO && expire)
                rd_q <= bus_din;
        end
    end

    assign load      = (state_d != state_q);
    assign busy      = (state_q != ST_IDLE);
    assign req_ready = (state_q == ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign rd_data   = rd_q;
    assign dout      = dout_q;
    assign rd_dc     = rd_dc_q;

    assert_dout_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && $past(wr_act)) |-> $stable(dout));
    assert_pl_ready_strobe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> !wr_act);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_err_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_act && rd_act));
    assert_strobe_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act || rd_act) |-> cs_act);
endmodule

// File: rtl/pbus_master.sv
module pbus_master
    import pbus_pkg::*;
#(
    parameter int DW      = 8,
    parameter int MAX_LEN = 1024,
    parameter int DIVW    = 8,
    localparam int LENW   = $clog2(MAX_LEN + 1) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] cfg_div,
    input  logic            cfg_cs_high,
    input  logic            cfg_wr_inv,
    input  logic            cfg_dc_idle,
    input  logic            cfg_dc_cmd,
    input  logic            cfg_dc_dummy,
    input  logic            cfg_dc_data,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_read,
    input  logic            req_has_cmd,
    input  logic [DW-1:0]   req_cmd,
    input  logic [LENW-1:0] req_len,
    input  logic            req_rd_dc,
    input  logic            pl_valid,
    output logic            pl_ready,
    input  logic [DW-1:0]   pl_data,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [DW-1:0]   rd_data,
    output logic            bus_cs,
    output logic            bus_wr,
    output logic            bus_rd,
    output logic            bus_dc,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_oe,
    input  logic [DW-1:0]   bus_din
);
    logic    reject, expire, load;
    logic    cs_act, wr_act, rd_act, rd_dc;
    dc_sel_t dc_sel;

    pbus_req_filter #(.MAX_LEN(MAX_LEN), .LENW(LENW)) u_filter (
        .req_read    (req_read),
        .req_has_cmd (req_has_cmd),
        .req_len     (req_len),
        .reject      (reject)
    );

    pbus_phase_timer #(.DIVW(DIVW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .cfg_div (cfg_div),
        .expire  (expire)
    );

    pbus_seq #(.DW(DW), .LENW(LENW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_read    (req_read),
        .req_has_cmd (req_has_cmd),
        .req_cmd     (req_cmd),
        .req_len     (req_len),
        .req_rd_dc   (req_rd_dc),
        .reject      (reject),
        .expire      (expire),
        .pl_valid    (pl_valid),
        .pl_data     (pl_data),
        .bus_din     (bus_din),
        .req_ready   (req_ready),
        .pl_ready    (pl_ready),
        .load        (load),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .rd_data     (rd_data),
        .dout        (bus_dout),
        .oe          (bus_oe),
        .cs_act      (cs_act),
        .wr_act      (wr_act),
        .rd_act      (rd_act),
        .dc_sel      (dc_sel),
        .rd_dc       (rd_dc)
    );

    pbus_pin_map u_pins (
        .cs_act       (cs_act),
        .wr_act       (wr_act),
        .rd_act       (rd_act),
        .dc_sel       (dc_sel),
        .rd_dc        (rd_dc),
        .cfg_cs_high  (cfg_cs_high),
        .cfg_wr_inv   (cfg_wr_inv),
        .cfg_dc_idle  (cfg_dc_idle),
        .cfg_dc_cmd   (cfg_dc_cmd),
        .cfg_dc_dummy (cfg_dc_dummy),
        .cfg_dc_data  (cfg_dc_data),
        .bus_cs       (bus_cs),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_dc       (bus_dc)
    );

    assert_no_drive_while_reading_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> !bus_oe);
    assert_busy_means_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bus_cs == cfg_cs_high));
    assert_ready_mirrors_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready != busy);
    assert_idle_dc_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_dc == cfg_dc_idle));
endmodule

// File: tb/pbus_master_bench.sv
module pbus_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int MAX_LEN = 1024;
    localparam int DIVW = 8;
    localparam int LENW = $clog2(MAX_LEN + 1) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIVW-1:0] cfg_div = '0;
    logic cfg_cs_high = 0, cfg_wr_inv = 0;
    logic cfg_dc_idle = 0, cfg_dc_cmd = 0, cfg_dc_dummy = 0, cfg_dc_data = 1;
    logic req_valid = 0, req_read = 0, req_has_cmd = 0, req_rd_dc = 0;
    logic [DW-1:0] req_cmd = '0;
    logic [LENW-1:0] req_len = '0;
    logic pl_valid = 0;
    logic [DW-1:0] pl_data = '0;
    logic [DW-1:0] bus_din = '0;
    logic req_ready, pl_ready, busy, done, err;
    logic [DW-1:0] rd_data, bus_dout;
    logic bus_cs, bus_wr, bus_rd, bus_dc, bus_oe;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_master #(.DW(DW), .MAX_LEN(MAX_LEN), .DIVW(DIVW)) u_pbus_master (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .cfg_cs_high(cfg_cs_high), .cfg_wr_inv(cfg_wr_inv),
        .cfg_dc_idle(cfg_dc_idle), .cfg_dc_cmd(cfg_dc_cmd),
        .cfg_dc_dummy(cfg_dc_dummy), .cfg_dc_data(cfg_dc_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_has_cmd(req_has_cmd), .req_cmd(req_cmd), .req_len(req_len),
        .req_rd_dc(req_rd_dc), .pl_valid(pl_valid), .pl_ready(pl_ready),
        .pl_data(pl_data), .busy(busy), .done(done), .err(err),
        .rd_data(rd_data), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_dc(bus_dc), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference: a segment player ----------------
    // dc codes: 0 idle, 1 cmd, 2 dummy, 3 data, 4 requested
    typedef struct {
        bit wt; bit cs; bit wr; bit rd; bit oe; int dc; bit cap;
    } seg_t;

    seg_t sq[$];
    bit m_active = 0, m_done = 0, m_err = 0, m_pop = 0, m_rd_dc = 0;
    int m_left = 0;
    logic [DW-1:0] m_dout = '0, m_rd = '0;

    function automatic seg_t mk(bit wt, bit wr, bit rd, bit oe, int dc, bit cap);
        seg_t s;
        s.wt = wt; s.cs = 1; s.wr = wr; s.rd = rd; s.oe = oe; s.dc = dc; s.cap = cap;
        return s;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq.delete(); m_active = 0; m_done = 0; m_err = 0;
            m_dout = '0; m_rd = '0; m_left = 0; m_rd_dc = 0;
        end else begin
            m_done = 0; m_err = 0; m_pop = 0;
            if (m_active) begin
                if (sq[0].wt) begin
                    if (pl_valid) begin m_dout = pl_data; m_pop = 1; end
                end else begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin
                        if (sq[0].cap) m_rd = bus_din;
                        m_pop = 1;
                    end
                end
                if (m_pop) begin
                    void'(sq.pop_front());
                    if (sq.size() == 0) begin m_active = 0; m_done = 1; end
                    else m_left = int'(cfg_div) + 1;
                end
            end else if (req_valid) begin
                if (!req_read && (int'(req_len) > MAX_LEN || (!req_has_cmd && req_len == 0))) begin
                    m_err = 1;
                end else begin
                    m_active = 1;
                    m_left = int'(cfg_div) + 1;
                    m_rd_dc = req_rd_dc;
                    if (req_read) begin
                        sq.push_back(mk(0, 0, 0, 0, 2, 0));
                        sq.push_back(mk(0, 0, 1, 0, 4, 1));
                        sq.push_back(mk(0, 0, 0, 0, 2, 0));
                    end else begin
                        if (req_has_cmd) begin
                            m_dout = req_cmd;
                            sq.push_back(mk(0, 0, 0, 1, 1, 0));
                            sq.push_back(mk(0, 1, 0, 1, 1, 0));
                        end
                        for (int i = 0; i < int'(req_len); i++) begin
                            sq.push_back(mk(1, 0, 0, 1, 3, 0));
                            sq.push_back(mk(0, 0, 0, 1, 3, 0));
                            sq.push_back(mk(0, 1, 0, 1, 3, 0));
                        end
                        sq.push_back(mk(0, 0, 0, 1, (req_len == 0) ? 1 : 3, 0));
                    end
                end
            end
        end
    end

    function automatic bit dc_level(int code);
        case (code)
            1: return cfg_dc_cmd;
            2: return cfg_dc_dummy;
            3: return cfg_dc_data;
            4: return m_rd_dc;
            default: return cfg_dc_idle;
        endcase
    endfunction

    // every-clock comparison, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            seg_t c;
            bit e_cs, e_wr;
            c = m_active ? sq[0] : mk(0, 0, 0, 1, 0, 0);
            if (!m_active) c.cs = 0;
            e_cs = cfg_cs_high ? c.cs : !c.cs;
            e_wr = cfg_wr_inv ? c.wr : !c.wr;
            chk(bus_cs == e_cs, "R1 bus_cs", bus_cs, e_cs);
            chk(bus_wr == e_wr, "R2 bus_wr", bus_wr, e_wr);
            chk(bus_dout == m_dout, "R2 bus_dout", bus_dout, m_dout);
            chk(bus_dc == dc_level(c.dc), "R4 bus_dc", bus_dc, dc_level(c.dc));
            chk(bus_rd == !c.rd, "R5 bus_rd", bus_rd, !c.rd);
            chk(bus_oe == c.oe, "R5 bus_oe", bus_oe, c.oe);
            chk(busy == m_active, "R7 busy", busy, m_active);
            chk(req_ready == !m_active, "R7 req_ready", req_ready, !m_active);
            chk(done == m_done, "R7 done", done, m_done);
            chk(err == m_err, "R6 err", err, m_err);
            chk(pl_ready == (m_active && c.wt), "R8 pl_ready", pl_ready, m_active && c.wt);
            if (m_done) chk(rd_data == m_rd, "R5 rd_data", rd_data, m_rd);
        end
    end

    // ---------------- strobe monitor for word order and phase lengths ----------------
    int wr_len = 0, rd_len = 0, cs_cycles = 0;
    logic [DW-1:0] last_word;
    bit last_dc;
    int cap_word[$];
    int cap_dc[$];

    always @(negedge clk) begin
        if (!rst_n) begin
            wr_len = 0; rd_len = 0;
        end else begin
            if (bus_cs == cfg_cs_high) cs_cycles++;
            if (cfg_wr_inv ? bus_wr : !bus_wr) begin
                wr_len++; last_word = bus_dout; last_dc = bus_dc;
            end else if (wr_len > 0) begin
                chk(wr_len == int'(cfg_div) + 1, "R9 write low length", wr_len, int'(cfg_div) + 1);
                cap_word.push_back(int'(last_word));
                cap_dc.push_back(int'(last_dc));
                wr_len = 0;
            end
            if (!bus_rd) rd_len++;
            else if (rd_len > 0) begin
                chk(rd_len == int'(cfg_div) + 1, "R9 read low length", rd_len, int'(cfg_div) + 1);
                rd_len = 0;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic feed(input int n, input int base, input int gap);
        for (int i = 0; i < n; i++) begin
            pl_valid = 0;
            repeat ((i % 3) * gap) @(negedge clk);
            pl_valid = 1;
            pl_data = DW'(base + i);
            while (!pl_ready) @(negedge clk);
            @(negedge clk);
        end
        pl_valid = 0;
    endtask

    task automatic issue(input bit rd, input bit hc, input int cmd, input int len, input bit rdc);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_read = rd; req_has_cmd = hc;
        req_cmd = DW'(cmd); req_len = LENW'(len); req_rd_dc = rdc;
        @(negedge clk);
        req_valid = 0;
        while (!(done || err)) @(negedge clk);
    endtask

    task automatic write_and_check(input bit hc, input int cmd, input int len,
                                   input int base, input int gap);
        cap_word.delete(); cap_dc.delete();
        fork
            issue(0, hc, cmd, len, 0);
            feed(len, base, gap);
        join
        chk(cap_word.size() == len + (hc ? 1 : 0), "R3 word count",
            cap_word.size(), len + (hc ? 1 : 0));
        for (int i = 0; i < cap_word.size(); i++) begin
            int ew; int ed;
            if (hc && i == 0) begin ew = cmd; ed = cfg_dc_cmd; end
            else begin ew = (base + i - (hc ? 1 : 0)) % 256; ed = cfg_dc_data; end
            chk(cap_word[i] == ew, "R3 word value", cap_word[i], ew);
            chk(cap_dc[i] == ed, "R3 word dc level", cap_dc[i], ed);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        // reset state, R1 R2 R4 R7
        chk(bus_cs == 1'b1, "R1 reset cs inactive", bus_cs, 1);
        chk(bus_wr == 1'b1, "R2 reset wr idle high", bus_wr, 1);
        chk(bus_dc == cfg_dc_idle, "R4 reset dc idle", bus_dc, cfg_dc_idle);
        chk(busy == 1'b0 && req_ready == 1'b1, "R7 reset not busy", busy, 0);
        rst_n = 1;

        // command plus burst, fastest rate (R3, R9)
        cfg_div = 0;
        write_and_check(1, 'h2A, 3, 'h10, 0);

        // data-only burst with stalls at a slower rate (R8)
        cfg_div = 2;
        write_and_check(0, 0, 5, 'h40, 4);

        // read with requested level high (R5, R4 dummy)
        cfg_div = 1; cfg_dc_dummy = 1; bus_din = 'hC3;
        issue(1, 0, 0, 0, 1);
        chk(rd_data == 'hC3, "R5 captured word", rd_data, 'hC3);

        // inverted polarities, command only (R1, R2, R3)
        cfg_cs_high = 1; cfg_wr_inv = 1; cfg_dc_idle = 1; cfg_dc_cmd = 1; cfg_dc_data = 0;
        repeat (2) @(negedge clk);
        chk(bus_cs == 1'b0 && bus_wr == 1'b0, "R1 inverted idle pins", {bus_cs, bus_wr}, 0);
        write_and_check(1, 'h29, 0, 0, 0);
        write_and_check(1, 'h2C, 4, 'h80, 2);

        // rejections (R6)
        cs_cycles = 0;
        issue(0, 1, 'h11, MAX_LEN + 1, 0);
        chk(err == 1'b1, "R6 err on overlong", err, 1);
        issue(0, 0, 0, 0, 0);
        chk(err == 1'b1, "R6 err on empty write", err, 1);
        repeat (2) @(negedge clk);
        chk(cs_cycles == 0, "R6 no bus activity on reject", cs_cycles, 0);

        // read at low requested level after polarity change (R5)
        cfg_div = 3; bus_din = 'h5E;
        issue(1, 0, 0, 4000, 0);
        chk(rd_data == 'h5E, "R5 captured word low dc", rd_data, 'h5E);

        // longest legal burst (R6 boundary, R3)
        cfg_cs_high = 0; cfg_wr_inv = 0; cfg_div = 0;
        write_and_check(0, 0, MAX_LEN, 'h00, 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule